// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a parameterized set of external interrupt lines (sixteen by default) and presents a single interrupt request to one processor. Each line has a configuration word with a vector, a 4-bit priority, a trigger type (edge or level), an active polarity, a mask bit and a read-only in-service flag. Each line also has a routing word whose bit 0 must be set for the line to reach the processor. Software reaches all state through a simple word-addressed register bus. The bus has a write strobe and a read strobe, and read data is returned in the same cycle.

When the processor takes the interrupt, it reads the claim register. The block returns the vector of the best candidate and marks that source in service. If no source qualifies, the read returns a programmable idle vector. A write to the completion register ends service of the innermost claimed source. A processor threshold register filters out low-priority work. A self-clearing soft-reset bit in the control register returns every setting to its default.

Word addresses: 0 identity (read-only), 1 control, 2 idle vector, 3 threshold, 4 claim, 5 completion. Source i has its configuration word at 16+2i and its routing word at 17+2i.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After hardware reset, every configuration word reads 0x8000_0000 (masked, priority 0, vector 0, edge, falling) and every routing word reads 0. The threshold reads 15, the idle vector reads 0xFF, the control word reads 0 and `irq_out` is low.
- R2: The identity word reads the version code in bits [2:0] (default 2), the last processor index in bits [12:8] (0) and the last source index in bits [26:16] (NUM_SRC-1). The default value is 0x000F_0002.
- R3: In a configuration word, bit 22 selects the trigger: 0 is edge, 1 is level. Bit 23 selects polarity: 1 is active-high or rising, 0 is active-low or falling. An edge source latches a pending flag on its selected edge only. The flag is cleared when that source is claimed.
- R4: A level source is pending for exactly as long as its input is at its active level. It stays pending after claim and completion.
- R5: Bit 31 of a configuration word is the mask. A masked source is never signalled or claimed. A written mask value reads back on the next access.
- R6: A source is delivered only while bit 0 of its routing word is 1.
- R7: A source is delivered only if its priority (bits [19:16]) is strictly greater than the threshold, and also strictly greater than the priority of every source in service. A threshold of 15 blocks everything.
- R8: A read of the claim register returns, in bits [7:0], the vector (bits [7:0] of the configuration word) of the deliverable source with the highest priority. The lowest index wins a tie. When nothing is deliverable, the read returns the idle vector.
- R9: Bit 30 of a configuration word (read-only) is set by a claim of that source. A write of any value to the completion register clears it for the source with the highest priority among those in service, which is the most recently claimed one. A source in service is not delivered again.
- R10: Writing 1 to bit 31 of the control word resets all settings and flags to the R1 values. The bit reads 1 for RST_CYCLES cycles (default 4) and then clears by itself. Writes made while it is set are ignored.
- R11: `irq_out` is registered. It rises one clock after a source becomes deliverable and falls one clock after none is deliverable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_SRC | External interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (claim read has a side effect) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the assertions check the following rules. A threshold of 15 keeps the request low. A claim read with no candidate returns the idle vector. Each successful claim adds exactly one in-service flag, and each completion removes exactly one. A reset in progress leaves every source masked. The request never rises without a deliverable source in the cycle before. Only the bench scenarios show which vector wins: lowest index on ties, nested preemption by higher priority, and blocking by an equal-priority source in service. They also show that rising and falling edges are told apart, that level sources persist, and that routing and masking readback work.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
    localparam int PRIO_W = 4;
    localparam int VEC_W  = 8;

    // word addresses
    localparam int A_IDENT  = 0;
    localparam int A_CTRL   = 1;
    localparam int A_IDLE   = 2;
    localparam int A_THRESH = 3;
    localparam int A_CLAIM  = 4;
    localparam int A_DONE   = 5;
    localparam int SRC_BASE = 16;

    // configuration word bit positions
    localparam int B_MASK  = 31;
    localparam int B_BUSY  = 30;
    localparam int B_POL   = 23;
    localparam int B_LEVEL = 22;
    localparam int B_PRIO  = 16;
    localparam int B_SRST  = 31;

    typedef struct packed {
        logic              mask;
        logic              pol;
        logic              level;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
        logic              route;
    } src_cfg_t;

    localparam src_cfg_t CFG_DEFAULT = '{mask: 1'b1, pol: 1'b0, level: 1'b0,
                                         prio: '0, vec: '0, route: 1'b0};
endpackage

// File: rtl/prio_irq_detect.sv
`timescale 1ns/1ps
module prio_irq_detect #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic [NUM_SRC-1:0] level,
    input  logic [NUM_SRC-1:0] pol,
    input  logic [NUM_SRC-1:0] clr_pend,
    input  logic               flush,
    output logic [NUM_SRC-1:0] pending
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] epend;
    } det_t;

    det_t det_d, det_q;
    logic [NUM_SRC-1:0] act_now, act_prev, edge_hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
        assign act_now[i]  = pol[i] ? irq_src[i]     : ~irq_src[i];
        assign act_prev[i] = pol[i] ? det_q.prev[i]  : ~det_q.prev[i];
        assign edge_hit[i] = act_now[i] & ~act_prev[i] & ~level[i];
        assign pending[i]  = level[i] ? act_now[i] : det_q.epend[i];
    end

    always_comb begin
        det_d.prev  = irq_src;
        det_d.epend = flush ? '0 : ((det_q.epend & ~clr_pend) | edge_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end
endmodule

// File: rtl/prio_irq_arb.sv
`timescale 1ns/1ps
module prio_irq_arb #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]        cand,
    input  logic [NUM_SRC-1:0]        active,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         thresh,
    output logic                      win_any,
    output logic [IDX_W-1:0]          win_idx,
    output logic                      act_any,
    output logic [IDX_W-1:0]          act_idx
);
    logic [PRIO_W-1:0] act_best, win_best, floor_p;

    always_comb begin
        act_any  = 1'b0;
        act_idx  = '0;
        act_best = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (active[i] && (!act_any || prio_flat[i*PRIO_W +: PRIO_W] > act_best)) begin
                act_any  = 1'b1;
                act_idx  = IDX_W'(i);
                act_best = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
        floor_p = (act_any && act_best > thresh) ? act_best : thresh;
        win_any  = 1'b0;
        win_idx  = '0;
        win_best = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && prio_flat[i*PRIO_W +: PRIO_W] > floor_p &&
                (!win_any || prio_flat[i*PRIO_W +: PRIO_W] > win_best)) begin
                win_any  = 1'b1;
                win_idx  = IDX_W'(i);
                win_best = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl import prio_irq_pkg::*; #(
    parameter int NUM_SRC    = 16,
    parameter int RST_CYCLES = 4,
    parameter int VERSION    = 2,
    localparam int ADDR_W    = $clog2(SRC_BASE + 2*NUM_SRC),
    localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CNT_W     = $clog2(RST_CYCLES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_out
);
    typedef struct packed {
        src_cfg_t [NUM_SRC-1:0] cfg;
        logic [NUM_SRC-1:0]     active;
        logic [PRIO_W-1:0]      thresh;
        logic [VEC_W-1:0]       idle_vec;
        logic                   busy;
        logic [CNT_W-1:0]       cnt;
        logic                   irq;
    } st_t;

    function automatic st_t st_default();
        st_t s;
        s = '0;
        for (int i = 0; i < NUM_SRC; i++) s.cfg[i] = CFG_DEFAULT;
        s.thresh   = '1;
        s.idle_vec = '1;
        return s;
    endfunction

    st_t st_d, st_q;

    logic [NUM_SRC-1:0]        sel_cfg, sel_route, level_v, pol_v, mask_v, route_v;
    logic [NUM_SRC-1:0]        pending, cand, clr_pend;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      win_any, act_any, win_ok, rst_req, flush, claim_fire;
    logic [IDX_W-1:0]          win_idx, act_idx;
    logic                      unused_wdata;

    assign unused_wdata = ^bus_wdata;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign sel_cfg[i]   = (bus_addr == ADDR_W'(SRC_BASE + 2*i));
        assign sel_route[i] = (bus_addr == ADDR_W'(SRC_BASE + 2*i + 1));
        assign level_v[i]   = st_q.cfg[i].level;
        assign pol_v[i]     = st_q.cfg[i].pol;
        assign mask_v[i]    = st_q.cfg[i].mask;
        assign route_v[i]   = st_q.cfg[i].route;
        assign prio_flat[i*PRIO_W +: PRIO_W] = st_q.cfg[i].prio;
    end

    assign cand = pending & ~mask_v & route_v & ~st_q.active;

    prio_irq_detect #(.NUM_SRC(NUM_SRC)) i_detect (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .level(level_v), .pol(pol_v),
        .clr_pend(clr_pend), .flush(flush), .pending(pending)
    );

    prio_irq_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_arb (
        .cand(cand), .active(st_q.active), .prio_flat(prio_flat), .thresh(st_q.thresh),
        .win_any(win_any), .win_idx(win_idx), .act_any(act_any), .act_idx(act_idx)
    );

    assign win_ok     = win_any & ~st_q.busy;
    assign rst_req    = bus_wr && bus_addr == ADDR_W'(A_CTRL) && bus_wdata[B_SRST] && !st_q.busy;
    assign flush      = st_q.busy | rst_req;
    assign claim_fire = bus_rd && bus_addr == ADDR_W'(A_CLAIM) && win_ok;

    always_comb begin
        st_d     = st_q;
        clr_pend = '0;
        st_d.irq = win_ok & ~rst_req;
        if (st_q.busy) begin
            st_d = st_default();
            if (st_q.cnt != CNT_W'(RST_CYCLES - 1)) begin
                st_d.busy = 1'b1;
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end else if (rst_req) begin
            st_d      = st_default();
            st_d.busy = 1'b1;
        end else begin
            if (bus_wr) begin
                if (bus_addr == ADDR_W'(A_IDLE))   st_d.idle_vec = bus_wdata[VEC_W-1:0];
                if (bus_addr == ADDR_W'(A_THRESH)) st_d.thresh   = bus_wdata[PRIO_W-1:0];
                if (bus_addr == ADDR_W'(A_DONE) && act_any) st_d.active[act_idx] = 1'b0;
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (sel_cfg[i]) begin
                        st_d.cfg[i].mask  = bus_wdata[B_MASK];
                        st_d.cfg[i].pol   = bus_wdata[B_POL];
                        st_d.cfg[i].level = bus_wdata[B_LEVEL];
                        st_d.cfg[i].prio  = bus_wdata[B_PRIO +: PRIO_W];
                        st_d.cfg[i].vec   = bus_wdata[VEC_W-1:0];
                    end
                    if (sel_route[i]) st_d.cfg[i].route = bus_wdata[0];
                end
            end
            if (claim_fire) begin
                st_d.active[win_idx] = 1'b1;
                clr_pend[win_idx]    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_default();
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_IDENT): begin
                bus_rdata[2:0]   = VERSION[2:0];
                bus_rdata[26:16] = 11'(NUM_SRC - 1);
            end
            ADDR_W'(A_CTRL):   bus_rdata[B_SRST] = st_q.busy;
            ADDR_W'(A_IDLE):   bus_rdata[VEC_W-1:0] = st_q.idle_vec;
            ADDR_W'(A_THRESH): bus_rdata[PRIO_W-1:0] = st_q.thresh;
            ADDR_W'(A_CLAIM):  bus_rdata[VEC_W-1:0] = win_ok ? st_q.cfg[win_idx].vec : st_q.idle_vec;
            default: begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (sel_cfg[i]) begin
                        bus_rdata[B_MASK]             = st_q.cfg[i].mask;
                        bus_rdata[B_BUSY]             = st_q.active[i];
                        bus_rdata[B_POL]              = st_q.cfg[i].pol;
                        bus_rdata[B_LEVEL]            = st_q.cfg[i].level;
                        bus_rdata[B_PRIO +: PRIO_W]   = st_q.cfg[i].prio;
                        bus_rdata[VEC_W-1:0]          = st_q.cfg[i].vec;
                    end
                    if (sel_route[i]) bus_rdata[0] = st_q.cfg[i].route;
                end
            end
        endcase
    end

    assign irq_out = st_q.irq;
endmodule

// File: rtl/prio_irq_chk.sv
`timescale 1ns/1ps
module prio_irq_chk import prio_irq_pkg::*; #(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_rdata,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] active,
    input logic [NUM_SRC-1:0] masks,
    input logic [PRIO_W-1:0]  thresh,
    input logic [VEC_W-1:0]   idle_vec,
    input logic               busy,
    input logic               win_ok
);
    p_thresh_max_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh == '1) |=> !irq_out);

    p_idle_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(A_CLAIM) && !win_ok) |-> (bus_rdata[VEC_W-1:0] == idle_vec));

    p_claim_marks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(A_CLAIM) && win_ok && !busy)
        |=> ($countones(active) == $past($countones(active)) + 1));

    p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_DONE) && !busy && (active != '0))
        |=> ($countones(active) + 1 == $past($countones(active))));

    p_reset_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (&masks));

    p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(win_ok));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .active(st_q.active), .masks(mask_v),
    .thresh(st_q.thresh), .idle_vec(st_q.idle_vec), .busy(st_q.busy), .win_ok(win_ok)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
    import prio_irq_pkg::*;
    localparam int N  = 16;
    localparam int AW = $clog2(SRC_BASE + 2*N);
    localparam int RSTC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_src = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_out;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N), .RST_CYCLES(RSTC)) i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] vp(bit m, bit a, bit p, bit l, int pr, int v);
        logic [31:0] w = '0;
        w[B_MASK] = m; w[B_BUSY] = a; w[B_POL] = p; w[B_LEVEL] = l;
        w[B_PRIO +: 4] = 4'(pr); w[7:0] = 8'(v);
        return w;
    endfunction

    task automatic note(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) note(1'b0, "scoreboard underflow", bus_rdata, '0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                note(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic wr(int a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, logic [31:0] e, string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = AW'(a);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_irq(bit e, string tag);
        @(negedge clk);
        note(irq_out === e, tag, {31'b0, irq_out}, {31'b0, e});
        @(posedge clk); #1;
    endtask

    function automatic int cw(int i); return SRC_BASE + 2*i;     endfunction
    function automatic int rw(int i); return SRC_BASE + 2*i + 1; endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 / R2 reset state
        rd(A_IDENT, 32'h000F_0002, "R2 identity word");
        rd(cw(0), 32'h8000_0000, "R1 cfg default");
        rd(rw(0), 32'h0, "R1 route default");
        rd(A_THRESH, 32'hF, "R1 threshold default");
        rd(A_IDLE, 32'hFF, "R1 idle vector default");
        rd(A_CTRL, 32'h0, "R1 control default");
        chk_irq(1'b0, "R1 irq low after reset");

        // level source, claim and completion
        wr(A_THRESH, 0);
        wr(cw(0), vp(0,0,1,1,5,8'h20));
        wr(rw(0), 1);
        rd(cw(0), vp(0,0,1,1,5,8'h20), "R5 cfg readback");
        irq_src[0] = 1'b1;
        idle(1);
        chk_irq(1'b1, "R11 irq rises for level source");
        rd(A_CLAIM, 8'h20, "R8 claim vector");
        rd(cw(0), vp(0,1,1,1,5,8'h20), "R9 in-service flag set");
        chk_irq(1'b0, "R9 in-service source not delivered");
        wr(A_DONE, 0);
        idle(1);
        chk_irq(1'b1, "R4 level source pending after completion");
        rd(cw(0), vp(0,0,1,1,5,8'h20), "R9 in-service flag cleared");
        irq_src[0] = 1'b0;
        rd(A_CLAIM, 8'hFF, "R8 idle vector when nothing pending");
        wr(A_IDLE, 8'h3C);
        rd(A_CLAIM, 8'h3C, "R8 programmed idle vector");

        // mask
        irq_src[0] = 1'b1;
        wr(cw(0), vp(1,0,1,1,5,8'h20));
        rd(cw(0), vp(1,0,1,1,5,8'h20), "R5 mask readback");
        idle(1);
        chk_irq(1'b0, "R5 masked source not signalled");
        rd(A_CLAIM, 8'h3C, "R5 masked source not claimed");
        wr(cw(0), vp(0,0,1,1,5,8'h20));
        idle(1);
        chk_irq(1'b1, "R5 unmasked source signalled");
        irq_src[0] = 1'b0;
        wr(cw(0), vp(1,0,1,1,5,8'h20));

        // routing
        wr(cw(1), vp(0,0,1,1,6,8'h31));
        irq_src[1] = 1'b1;
        idle(1);
        chk_irq(1'b0, "R6 unrouted source blocked");
        rd(A_CLAIM, 8'h3C, "R6 unrouted source not claimed");
        wr(rw(1), 1);
        idle(1);
        chk_irq(1'b1, "R6 routed source signalled");
        rd(A_CLAIM, 8'h31, "R6 routed source claimed");
        wr(A_DONE, 0);
        irq_src[1] = 1'b0;

        // threshold
        wr(cw(2), vp(0,0,1,1,4,8'h42));
        wr(rw(2), 1);
        wr(A_THRESH, 4);
        irq_src[2] = 1'b1;
        idle(1);
        chk_irq(1'b0, "R7 equal priority blocked");
        rd(A_CLAIM, 8'h3C, "R7 equal priority not claimed");
        wr(A_THRESH, 3);
        idle(1);
        chk_irq(1'b1, "R7 higher priority passes");
        wr(cw(2), vp(0,0,1,1,15,8'h42));
        wr(A_THRESH, 15);
        idle(1);
        chk_irq(1'b0, "R7 threshold 15 blocks all");
        rd(A_CLAIM, 8'h3C, "R7 threshold 15 claim idle");
        wr(A_THRESH, 0);
        irq_src[2] = 1'b0;

        // rising edges, tie
        wr(cw(3), vp(0,0,1,0,7,8'h53));
        wr(cw(4), vp(0,0,1,0,7,8'h54));
        wr(rw(3), 1);
        wr(rw(4), 1);
        irq_src[4:3] = 2'b11;
        idle(1);
        irq_src[4:3] = 2'b00;
        idle(1);
        rd(A_CLAIM, 8'h53, "R8 tie lowest index wins");
        rd(A_CLAIM, 8'h3C, "R7 equal priority in service blocks");
        wr(A_DONE, 0);
        rd(A_CLAIM, 8'h54, "R3 second edge still latched");
        wr(A_DONE, 0);
        rd(A_CLAIM, 8'h3C, "R3 edge flag cleared by claim");

        // falling edge
        wr(cw(5), vp(0,0,0,0,3,8'h65));
        wr(rw(5), 1);
        irq_src[5] = 1'b1;
        idle(2);
        rd(A_CLAIM, 8'h3C, "R3 rising ignored on falling source");
        irq_src[5] = 1'b0;
        idle(2);
        chk_irq(1'b1, "R3 falling edge latched");
        rd(A_CLAIM, 8'h65, "R3 falling edge claimed");
        wr(A_DONE, 0);

        // nesting
        wr(cw(6), vp(0,0,1,1,2,8'h76));
        wr(cw(7), vp(0,0,1,1,9,8'h87));
        wr(rw(6), 1);
        wr(rw(7), 1);
        irq_src[6] = 1'b1;
        rd(A_CLAIM, 8'h76, "R8 low priority claim");
        irq_src[7] = 1'b1;
        rd(A_CLAIM, 8'h87, "R7 higher priority preempts");
        rd(cw(6), vp(0,1,1,1,2,8'h76), "R9 outer in service");
        rd(cw(7), vp(0,1,1,1,9,8'h87), "R9 inner in service");
        wr(A_DONE, 0);
        rd(cw(7), vp(0,0,1,1,9,8'h87), "R9 completion ends inner");
        rd(cw(6), vp(0,1,1,1,2,8'h76), "R9 outer still in service");
        wr(A_DONE, 0);
        rd(cw(6), vp(0,0,1,1,2,8'h76), "R9 completion ends outer");
        irq_src[7:6] = 2'b00;

        // soft reset
        wr(A_CTRL, 32'h8000_0000);
        rd(A_CTRL, 32'h8000_0000, "R10 reset bit reads set");
        wr(A_THRESH, 2);
        idle(RSTC + 1);
        rd(A_CTRL, 32'h0, "R10 reset bit self clears");
        rd(cw(6), 32'h8000_0000, "R10 cfg restored");
        rd(A_THRESH, 32'hF, "R10 threshold restored, write while busy ignored");
        rd(A_IDLE, 32'hFF, "R10 idle vector restored");
        rd(rw(1), 32'h0, "R10 route restored");
        chk_irq(1'b0, "R10 irq low after soft reset");

        idle(2);
        summary();
        $finish;
    end
endmodule